// File: doc/BRIEF.md
# Dual-Enable Static RAM Functional Model

This block is a clocked, synthesizable stand-in for an asynchronous byte-wide static RAM of 8192 locations. It is meant to sit on the far side of a memory controller under test: the controller drives the address, two chip selects of opposite polarity, a write strobe, a read gate and write data, and the model answers as the real memory would. The analog timing is replaced by sampling every input on a fast clock. Each rising edge is one sample.

At every sample the model decodes the control lines into one of four modes: idle (deselected), store, fetch or hush (selected with the outputs off). A write is the span of samples in which the device is selected and the write strobe is low. The byte is committed when that span ends. The address and data used are the ones present at the last sample inside the span, which models a trailing-edge write. Instead of a tri-state bus, the model presents a data output and a registered drive flag. The drive flag is high only after a sample taken in fetch mode, so a bench can watch it for bus contention. The data output reads zero whenever the flag is low.

Top module: `dual_enable_sram`

## Requirements
- R1: While `chip_sel_n` is 1 at a sample, the mode is idle whatever the other inputs are. After that edge `drive` is 0 and `dout` is 0.
- R2: While `chip_sel` is 0 at a sample, the mode is idle whatever the other inputs are. After that edge `drive` is 0 and `dout` is 0.
- R3: A sample with `chip_sel_n`=0, `chip_sel`=1 and `wr_n`=0 is in store mode, whatever the level of `rd_gate_n`. After that edge `drive` is 0.
- R4: A sample with `chip_sel_n`=0, `chip_sel`=1, `wr_n`=1 and `rd_gate_n`=0 is in fetch mode. After that edge `drive` is 1 and `dout` holds the byte stored at `addr`.
- R5: A sample with `chip_sel_n`=0, `chip_sel`=1, `wr_n`=1 and `rd_gate_n`=1 is in hush mode. After that edge `drive` is 0 and `dout` is 0.
- R6: The array holds 8192 independent bytes, selected by all 13 bits of `addr`. Location 0x0000 and location 0x1FFF are distinct.
- R7: A write commits at the first sample that is no longer in store mode. It stores the data and address seen at the last store-mode sample, so a changed address or data at the closing sample has no effect.
- R8: A write span ended by deselecting (either chip select going inactive) still commits its byte.
- R9: When a write commits at a fetch-mode sample to the same address, `dout` after that edge shows the newly committed byte.
- R10: `drive` falls at the first edge whose sample is not in fetch mode. `dout` is 0 whenever `drive` is 0.
- R11: A synchronous active-high `rst` forces `drive` to 0 and `dout` to 0, and it discards a write span that is open during reset. No byte is committed for that span.
- R12: If the device becomes selected at the same sample as the write strobe falls, or after it, `drive` stays 0 for the whole write span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 13 | Location address |
| chip_sel_n | input | 1 | Chip select, active low |
| chip_sel | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_gate_n | input | 1 | Read output gate, active low |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| drive | output | 1 | High when the data pins would be driven |

## Verification
Two functions can fall on the same sample: a write span closes by raising the write strobe while the read gate is already low, and the same sample then starts a fetch of the address just written. The bench provokes this by holding the read gate low through a store span and releasing only the write strobe. It judges the result by requiring that `drive` is high and `dout` shows the newly written byte after that edge, not the old content. The same idea covers a span closed by deselecting, which must commit while the outputs stay quiet.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

  // Operating mode decoded from one sample of the control lines
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_STORE = 2'd1,
    MODE_FETCH = 2'd2,
    MODE_HUSH  = 2'd3
  } sram_mode_e;

endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import sram_model_pkg::*;
(
  input  logic       chip_sel_n,
  input  logic       chip_sel,
  input  logic       wr_n,
  input  logic       rd_gate_n,
  output sram_mode_e mode,
  output logic       overlap
);

  logic selected;

  always_comb begin
    selected = !chip_sel_n && chip_sel;
    if (!selected)      mode = MODE_IDLE;   // either select inactive wins
    else if (!wr_n)     mode = MODE_STORE;  // read gate ignored
    else if (!rd_gate_n) mode = MODE_FETCH;
    else                mode = MODE_HUSH;
    overlap = (mode == MODE_STORE);
  end

endmodule

// File: rtl/sram_write_track.sv
module sram_write_track #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              overlap,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic              open_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  // Capture address and data at every sample inside the span, so the
  // last one inside is what commits when the span closes.
  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
    end else begin
      open_q <= overlap;
    end
    if (overlap) begin
      addr_q <= addr;
      data_q <= din;
    end
  end

  always_comb begin
    commit  = open_q && !overlap && !rst;
    wr_addr = addr_q;
    wr_data = data_q;
  end

  // R7: a commit is only ever preceded by a store sample
  p_commit_after_span_r7: assert property (@(posedge clk) disable iff (rst)
    commit |-> $past(overlap));

  // R11: a span open across reset never commits on the first sample after it
  p_reset_discards_r11: assert property (@(posedge clk)
    $past(rst) |-> !commit);

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] byp_data_q;
  logic              byp_q;

  // Plain one-write one-read array, kept free of reset for RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (rd_en) rd_q <= mem[raddr];
  end

  // Write-first forwarding held outside the array
  always_ff @(posedge clk) begin
    byp_q      <= we && rd_en && (waddr == raddr);
    byp_data_q <= wdata;
  end

  assign rdata = byp_q ? byp_data_q : rd_q;

endmodule

// File: rtl/dual_enable_sram.sv
module dual_enable_sram
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chip_sel_n,
  input  logic              chip_sel,
  input  logic              wr_n,
  input  logic              rd_gate_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);

  sram_mode_e        mode;
  logic              overlap;
  logic              commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] arr_data;
  logic              fetch_now;
  logic              drive_q;

  sram_mode_decode u_decode (
    .chip_sel_n (chip_sel_n),
    .chip_sel   (chip_sel),
    .wr_n       (wr_n),
    .rd_gate_n  (rd_gate_n),
    .mode       (mode),
    .overlap    (overlap)
  );

  sram_write_track #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_track (
    .clk     (clk),
    .rst     (rst),
    .overlap (overlap),
    .addr    (addr),
    .din     (din),
    .commit  (commit),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  assign fetch_now = (mode == MODE_FETCH);

  sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (commit),
    .waddr (wr_addr),
    .wdata (wr_data),
    .rd_en (fetch_now),
    .raddr (addr),
    .rdata (arr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) drive_q <= 1'b0;
    else     drive_q <= fetch_now;
  end

  assign drive = drive_q;
  assign dout  = drive_q ? arr_data : '0;

  // R1: active-low select high keeps the pins quiet
  p_desel_high_r1: assert property (@(posedge clk) disable iff (rst)
    chip_sel_n |=> (!drive && dout == '0));

  // R2: active-high select low keeps the pins quiet
  p_desel_low_r2: assert property (@(posedge clk) disable iff (rst)
    !chip_sel |=> (!drive && dout == '0));

  // R3: store samples never drive, read gate notwithstanding
  p_store_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel_n && chip_sel && !wr_n) |=> !drive);

  // R4: fetch samples drive on the next edge
  p_fetch_drives_r4: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel_n && chip_sel && wr_n && !rd_gate_n) |=> drive);

  // R5: hush samples leave the pins off
  p_hush_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!chip_sel_n && chip_sel && wr_n && rd_gate_n) |=> (!drive && dout == '0));

  // R9: commit and fetch on one sample, same address, forward the new byte
  p_fresh_on_commit_r9: assert property (@(posedge clk) disable iff (rst)
    (commit && fetch_now && wr_addr == addr) |=> (dout == $past(wr_data)));

  // R10: drive falls on the first non-fetch sample
  p_drop_leave_r10: assert property (@(posedge clk) disable iff (rst)
    (drive && !fetch_now) |=> !drive);

  // R11: reset silences the outputs
  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (!drive && dout == '0));

endmodule

// File: tb/dual_enable_sram_tb_top.sv
module dual_enable_sram_tb_top;

  localparam int AW = 13;
  localparam int DW = 8;
  localparam int NV = 21;

  // {sel_n, sel, wr_n, gate_n, addr[13], din[8], exp_drive, exp_dout[8], req[4]}
  localparam logic [37:0] VEC [NV] = '{
    {4'b1110, 13'h0010, 8'h00, 1'b0, 8'h00, 4'd1},  // R1 idle by active-low select
    {4'b0101, 13'h0010, 8'hA5, 1'b0, 8'h00, 4'd3},  // R3 store 0x10
    {4'b0111, 13'h0010, 8'h00, 1'b0, 8'h00, 4'd5},  // R5 hush, commit
    {4'b0110, 13'h0010, 8'h00, 1'b1, 8'hA5, 4'd4},  // R4 fetch 0x10
    {4'b0111, 13'h0010, 8'h00, 1'b0, 8'h00, 4'd10}, // R10 drive drops
    {4'b0010, 13'h0010, 8'h00, 1'b0, 8'h00, 4'd2},  // R2 idle by active-high select
    {4'b0100, 13'h1FFF, 8'h3C, 1'b0, 8'h00, 4'd3},  // R3 store, gate low ignored
    {4'b0100, 13'h1FFF, 8'h3C, 1'b0, 8'h00, 4'd3},  // R3 span continues
    {4'b0110, 13'h1FFF, 8'h00, 1'b1, 8'h3C, 4'd9},  // R9 commit and fetch together
    {4'b0110, 13'h0010, 8'h00, 1'b1, 8'hA5, 4'd6},  // R6 low location intact
    {4'b1100, 13'h0000, 8'h77, 1'b0, 8'h00, 4'd12}, // R12 strobe low before select
    {4'b0100, 13'h0000, 8'h77, 1'b0, 8'h00, 4'd12}, // R12 selected after strobe
    {4'b1100, 13'h0000, 8'h00, 1'b0, 8'h00, 4'd8},  // R8 deselect closes span
    {4'b0110, 13'h0000, 8'h00, 1'b1, 8'h77, 4'd8},  // R8 byte committed
    {4'b0101, 13'h0005, 8'h11, 1'b0, 8'h00, 4'd7},  // R7 span first data
    {4'b0101, 13'h0005, 8'h22, 1'b0, 8'h00, 4'd7},  // R7 span last data
    {4'b0111, 13'h0006, 8'h99, 1'b0, 8'h00, 4'd7},  // R7 closing sample ignored
    {4'b0110, 13'h0005, 8'h00, 1'b1, 8'h22, 4'd7},  // R7 trailing data kept
    {4'b0110, 13'h1FFF, 8'h00, 1'b1, 8'h3C, 4'd6},  // R6 top location intact
    {4'b0101, 13'h0030, 8'h11, 1'b0, 8'h00, 4'd3},  // R3 prepare 0x30
    {4'b0111, 13'h0030, 8'h00, 1'b0, 8'h00, 4'd5}   // R5 hush, commit
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          chip_sel_n, chip_sel, wr_n, rd_gate_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          drive;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dual_enable_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .chip_sel_n (chip_sel_n),
    .chip_sel   (chip_sel),
    .wr_n       (wr_n),
    .rd_gate_n  (rd_gate_n),
    .din        (din),
    .dout       (dout),
    .drive      (drive)
  );

  task automatic step(input logic [3:0] ctl, input logic [AW-1:0] a, input logic [DW-1:0] d);
    {chip_sel_n, chip_sel, wr_n, rd_gate_n} = ctl;
    addr = a;
    din  = d;
    @(posedge clk);
    #5;
  endtask

  task automatic chk(input string req, input logic edrv, input logic [DW-1:0] edout);
    n_checks++;
    if (drive !== edrv || dout !== edout) begin
      n_fail++;
      $display("FAIL %s: drive=%0b dout=%02h expected drive=%0b dout=%02h",
               req, drive, dout, edrv, edout);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    {chip_sel_n, chip_sel, wr_n, rd_gate_n} = 4'b1011;
    addr = '0;
    din  = '0;
    repeat (3) @(posedge clk);
    #5;
    chk("R11 reset state", 1'b0, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][37:34], VEC[i][33:21], VEC[i][20:13]);
      chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][12], VEC[i][11:4]);
    end

    // R11: span open across reset is discarded
    step(4'b0101, 13'h0030, 8'h5A);
    chk("R11 span before reset", 1'b0, 8'h00);
    rst = 1'b1;
    step(4'b0101, 13'h0030, 8'h5A);
    chk("R11 during reset", 1'b0, 8'h00);
    rst = 1'b0;
    step(4'b0111, 13'h0030, 8'h00);
    chk("R11 released, hush", 1'b0, 8'h00);
    step(4'b0110, 13'h0030, 8'h00);
    chk("R11 old byte kept", 1'b1, 8'h11);

    // R11: reset in the middle of a fetch silences the outputs
    step(4'b0110, 13'h0010, 8'h00);
    chk("R4 fetch before reset", 1'b1, 8'hA5);
    rst = 1'b1;
    step(4'b0110, 13'h0010, 8'h00);
    chk("R11 reset during fetch", 1'b0, 8'h00);
    rst = 1'b0;

    // R12: select and strobe arrive together, then gate held low
    step(4'b0100, 13'h0040, 8'hC3);
    chk("R12 joint arrival", 1'b0, 8'h00);
    step(4'b0100, 13'h0040, 8'hC3);
    chk("R12 span held", 1'b0, 8'h00);
    step(4'b1110, 13'h0040, 8'h00);
    chk("R1 deselect closes span", 1'b0, 8'h00);
    step(4'b0110, 13'h0040, 8'h00);
    chk("R8 committed by deselect", 1'b1, 8'hC3);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule